// File: doc/BRIEF.md
# Debug-to-Security Mailbox

This block gives a debug host a pair of single-word mailboxes into and out of on-chip security logic. The host side is a simple register port with four word registers in a 16-byte window: a transmit word, a transmit status/control word, a receive word, and a receive status/control word. Bit 0 of each status/control word is an availability flag. Only hardware moves these flags: a data write, a data read, or a handshake from the security side. Bits 31:1 carry free-form control side-band information.

Toward the security side, each direction is a valid/ready stream one word deep. On the transmit stream, `tx_valid` is the transmit flag itself. The security side takes the word by raising `tx_ready` for one cycle while `tx_valid` is high. `tx_ready` is ignored while `tx_valid` is low. On the receive stream, `rx_ready` is high while the receive word is empty. It is also high in a cycle where the host is reading the receive word. While `rx_ready` is low, the security side must hold `rx_valid`, `rx_data` and `rx_ctrl` steady.

Host reads answer one cycle after the access with `bus_rvalid`. The data is the register contents as they stood in the access cycle.

Top module: `dbg_sec_mailbox`

## Requirements
- R1: After reset every register reads zero, `tx_valid` is 0, `tx_ctrl` is 0, `rx_ready` is 1 and `bus_rvalid` is 0.
- R2: A host write to offset 0x200 loads `tx_data` at the next clock edge and raises `tx_valid`, which is bit 0 of the word at 0x204.
- R3: An edge with `tx_valid` and `tx_ready` both high and no transmit write clears `tx_valid`. `tx_ready` has no effect while `tx_valid` is low.
- R4: A transmit write while `tx_valid` is still high replaces `tx_data`, and `tx_valid` stays high. Without a transmit write, `tx_data` does not change.
- R5: If a transmit write and a transmit accept fall on the same edge, the write wins: `tx_valid` stays high with the new word.
- R6: Writing 0x204 stores bits 31:1 into `tx_ctrl`. Bit 0 of that write is ignored, and bits 31:1 read back with the flag in bit 0.
- R7: An edge with `rx_valid` and `rx_ready` high captures `rx_data` into 0x208 and `rx_ctrl` into bits 31:1 of 0x20C, and sets bit 0 of 0x20C. While that flag is set and the host is not reading 0x208, `rx_ready` is 0.
- R8: A host read of 0x208 returns the captured word and clears the receive flag at the same edge. Reading 0x20C does not clear it.
- R9: If a receive capture and a host read of 0x208 fall on the same edge, the capture wins. The read returns the old word, and the flag stays set with the new word.
- R10: A host read produces `bus_rvalid` high with data exactly one cycle later. A cycle with no read access gives `bus_rvalid` low one cycle later.
- R11: The following host writes have no effect: writes to 0x208 or 0x20C, writes outside 0x200–0x20F, and writes whose two low address bits are not zero. Reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| tx_valid | output | 1 | Transmit word pending (transmit flag) |
| tx_ready | input | 1 | Security side accepts the transmit word |
| tx_data | output | DATA_W | Transmit word |
| tx_ctrl | output | DATA_W-1 | Transmit control side-band |
| rx_valid | input | 1 | Security side offers a receive word |
| rx_ready | output | 1 | Mailbox can take a receive word |
| rx_data | input | DATA_W | Receive word |
| rx_ctrl | input | DATA_W-1 | Receive control side-band |

## Verification
A corrupt transmit flag is visible at once on `tx_valid`. A lost or extra accept shows as `tx_valid` in the wrong state on the very next cycle. A corrupt receive flag appears on `rx_ready` within the cycle, unless a receive-word read happens to be in flight at that moment. It also appears in bit 0 of a status read one cycle after the read. Stored words and side-bands are compared on every cycle at the transmit pins. On the receive side they are checked through every read response, so a wrong capture is caught at the first read after it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_REGS = 4;
  localparam int IDX_W    = $clog2(NUM_REGS);

  typedef enum logic [IDX_W-1:0] {
    REG_TX_WORD = 2'd0,
    REG_TX_STAT = 2'd1,
    REG_RX_WORD = 2'd2,
    REG_RX_STAT = 2'd3
  } mbx_reg_e;

  typedef struct packed {
    logic     hit;
    logic     wr;
    mbx_reg_e idx;
  } mbx_access_t;
endpackage

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  // set has priority over clr
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode import mbx_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h200
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output mbx_access_t       acc
);
  localparam int WIN_LSB = IDX_W + 2;

  logic in_window;
  logic aligned;

  assign in_window = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  assign aligned   = (addr[1:0] == 2'b00);

  always_comb begin
    acc.hit = sel && in_window && aligned;
    acc.wr  = wr;
    acc.idx = mbx_reg_e'(addr[WIN_LSB-1:2]);
  end
endmodule

// File: rtl/mbx_tx_chan.sv
module mbx_tx_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_we,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-2:0] tx_ctrl,
  output logic              tx_avail
);
  logic accept;
  assign accept = tx_avail && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data <= '0;
      tx_ctrl <= '0;
    end else begin
      if (word_we) tx_data <= wdata;
      if (stat_we) tx_ctrl <= wdata[DATA_W-1:1];
    end
  end

  mbx_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (word_we),
    .clr   (accept),
    .q     (tx_avail)
  );
endmodule

// File: rtl/mbx_rx_chan.sv
module mbx_rx_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-2:0] rx_ctrl,
  input  logic              word_re,
  output logic              rx_ready,
  output logic [DATA_W-1:0] word_q,
  output logic [DATA_W-2:0] ctrl_q,
  output logic              rx_avail
);
  logic capture;

  // slot is free if empty, or if the host drains it this very cycle
  assign rx_ready = !rx_avail || word_re;
  assign capture  = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      ctrl_q <= '0;
    end else if (capture) begin
      word_q <= rx_data;
      ctrl_q <= rx_ctrl;
    end
  end

  mbx_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (capture),
    .clr   (word_re),
    .q     (rx_avail)
  );
endmodule

// File: rtl/dbg_sec_mailbox.sv
module dbg_sec_mailbox import mbx_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-2:0] tx_ctrl,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-2:0] rx_ctrl
);
  mbx_access_t       acc;
  logic              tx_word_we, tx_stat_we, rx_word_re, rd_any;
  logic              tx_avail, rx_avail;
  logic [DATA_W-1:0] rx_word_q;
  logic [DATA_W-2:0] rx_ctrl_q;
  logic [DATA_W-1:0] rd_mux;

  mbx_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .sel  (bus_sel),
    .wr   (bus_wr),
    .addr (bus_addr),
    .acc  (acc)
  );

  assign tx_word_we = acc.hit &&  acc.wr && (acc.idx == REG_TX_WORD);
  assign tx_stat_we = acc.hit &&  acc.wr && (acc.idx == REG_TX_STAT);
  assign rx_word_re = acc.hit && !acc.wr && (acc.idx == REG_RX_WORD);
  assign rd_any     = bus_sel && !bus_wr;

  mbx_tx_chan #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_we  (tx_word_we),
    .stat_we  (tx_stat_we),
    .wdata    (bus_wdata),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_ctrl  (tx_ctrl),
    .tx_avail (tx_avail)
  );

  mbx_rx_chan #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_ctrl  (rx_ctrl),
    .word_re  (rx_word_re),
    .rx_ready (rx_ready),
    .word_q   (rx_word_q),
    .ctrl_q   (rx_ctrl_q),
    .rx_avail (rx_avail)
  );

  assign tx_valid = tx_avail;

  always_comb begin
    rd_mux = '0;
    if (acc.hit) begin
      case (acc.idx)
        REG_TX_WORD: rd_mux = tx_data;
        REG_TX_STAT: rd_mux = {tx_ctrl, tx_avail};
        REG_RX_WORD: rd_mux = rx_word_q;
        REG_RX_STAT: rd_mux = {rx_ctrl_q, rx_avail};
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_any;
      if (rd_any) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rvalid,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rx_avail
);
  localparam logic [ADDR_W-1:0] A_TXW = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_RXW = BASE_ADDR + ADDR_W'(8);

  logic txw, rxr, rdacc, rxcap;
  assign txw   = bus_sel &&  bus_wr && (bus_addr == A_TXW);
  assign rxr   = bus_sel && !bus_wr && (bus_addr == A_RXW);
  assign rdacc = bus_sel && !bus_wr;
  assign rxcap = rx_valid && rx_ready;

  a_r2_tx_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    txw |=> (tx_valid && tx_data == $past(bus_wdata)));
  a_r3_tx_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !txw) |=> !tx_valid);
  a_r3_tx_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !txw) |=> !tx_valid);
  a_r4_tx_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !txw |=> $stable(tx_data));
  a_r5_tx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (txw && tx_valid && tx_ready) |=> tx_valid);
  a_r7_rx_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_avail && !rxr) |-> !rx_ready);
  a_r7_rx_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rxcap |=> rx_avail);
  a_r8_rx_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rxr && !rxcap) |=> !rx_avail);
  a_r10_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rdacc |=> bus_rvalid);
  a_r10_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !rdacc |=> !bus_rvalid);
endmodule

bind dbg_sec_mailbox mbx_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_avail   (rx_avail)
);

// File: tb/dbg_sec_mailbox_tb.sv
`timescale 1ns/1ps
module dbg_sec_mailbox_tb;
  localparam int DW = 32;
  localparam int AW = 10;
  localparam logic [AW-1:0] A_TXW = 10'h200;
  localparam logic [AW-1:0] A_TXS = 10'h204;
  localparam logic [AW-1:0] A_RXW = 10'h208;
  localparam logic [AW-1:0] A_RXS = 10'h20C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_rvalid, tx_valid, rx_ready;
  logic tx_ready = 1'b0, rx_valid = 1'b0;
  logic [DW-1:0] tx_data;
  logic [DW-2:0] tx_ctrl;
  logic [DW-1:0] rx_data = '0;
  logic [DW-2:0] rx_ctrl = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit running = 1'b0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  dbg_sec_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_ctrl(tx_ctrl), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_ctrl(rx_ctrl)
  );

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0] m_txd, m_rxd;
  logic [DW-2:0] m_txc, m_rxc;
  bit m_txa, m_rxa, m_rv;
  logic [DW-1:0] exp_q[$];

  function automatic bit model_rx_ready();
    return !m_rxa || (bus_sel && !bus_wr && bus_addr == A_RXW);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_txd = '0; m_rxd = '0; m_txc = '0; m_rxc = '0;
      m_txa = 0; m_rxa = 0; m_rv = 0;
      exp_q.delete();
    end else begin
      bit rdy, acc, rd_rx;
      logic [DW-1:0] rv;
      rdy   = model_rx_ready();
      acc   = rx_valid && rdy;
      rd_rx = bus_sel && !bus_wr && bus_addr == A_RXW;
      m_rv  = bus_sel && !bus_wr;
      if (m_rv) begin
        if      (bus_addr == A_TXW) rv = m_txd;
        else if (bus_addr == A_TXS) rv = {m_txc, m_txa};
        else if (bus_addr == A_RXW) rv = m_rxd;
        else if (bus_addr == A_RXS) rv = {m_rxc, m_rxa};
        else                        rv = '0;
        exp_q.push_back(rv);
      end
      if (bus_sel && bus_wr && bus_addr == A_TXW) begin
        m_txd = bus_wdata; m_txa = 1;
      end else if (m_txa && tx_ready) m_txa = 0;
      if (bus_sel && bus_wr && bus_addr == A_TXS) m_txc = bus_wdata[DW-1:1];
      if (acc) begin
        m_rxd = rx_data; m_rxc = rx_ctrl; m_rxa = 1;
      end else if (rd_rx) m_rxa = 0;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk("R2/R3 tx_valid vs model", {31'd0, tx_valid}, {31'd0, m_txa});
      chk("R4 tx_data vs model", tx_data, m_txd);
      chk("R6 tx_ctrl vs model", {1'b0, tx_ctrl}, {1'b0, m_txc});
      chk("R7 rx_ready vs model", {31'd0, rx_ready}, {31'd0, model_rx_ready()});
      chk("R10 bus_rvalid vs model", {31'd0, bus_rvalid}, {31'd0, m_rv});
      if (bus_rvalid && exp_q.size() > 0) begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk("R10 bus_rdata vs model", bus_rdata, e);
      end
    end
  end

  // ---------------- stimulus tasks (start at negedge + 1) ----------------
  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_sel = 0; bus_wr = 0;
    chk("R10 no rvalid after write", {31'd0, bus_rvalid}, 32'd0);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    #1;
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic pulse_tx_ready();
    tx_ready = 1;
    @(negedge clk); #1;
    tx_ready = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    running = 1;
    idle(1);
    // R1: reset state
    chk("R1 tx_valid reset", {31'd0, tx_valid}, 32'd0);
    chk("R1 rx_ready reset", {31'd0, rx_ready}, 32'd1);
    chk("R1 tx_ctrl reset", {1'b0, tx_ctrl}, 32'd0);
    chk("R1 rvalid reset", {31'd0, bus_rvalid}, 32'd0);
    bus_read(A_TXW, 32'h0, "R1 tx word reads zero");
    bus_read(A_TXS, 32'h0, "R1 tx status reads zero");
    bus_read(A_RXW, 32'h0, "R1 rx word reads zero");
    bus_read(A_RXS, 32'h0, "R1 rx status reads zero");

    // R3: ready with no pending word does nothing
    pulse_tx_ready();
    chk("R3 ready ignored while idle", {31'd0, tx_valid}, 32'd0);

    // R2: transmit write
    bus_write(A_TXW, 32'hA5A5_0001);
    chk("R2 tx_valid set", {31'd0, tx_valid}, 32'd1);
    chk("R2 tx_data loaded", tx_data, 32'hA5A5_0001);
    bus_read(A_TXS, 32'h1, "R2 status flag reads one");

    // R4: overwrite while pending
    bus_write(A_TXW, 32'h0BAD_F00D);
    chk("R4 overwrite data", tx_data, 32'h0BAD_F00D);
    chk("R4 flag stays", {31'd0, tx_valid}, 32'd1);
    idle(2);
    chk("R4 data held", tx_data, 32'h0BAD_F00D);

    // R3: accept clears
    pulse_tx_ready();
    chk("R3 accept clears flag", {31'd0, tx_valid}, 32'd0);

    // R5: write and accept in same cycle
    bus_write(A_TXW, 32'h1111_2222);
    bus_sel = 1; bus_wr = 1; bus_addr = A_TXW; bus_wdata = 32'h3333_4444; tx_ready = 1;
    @(negedge clk); #1;
    bus_sel = 0; bus_wr = 0; tx_ready = 0;
    chk("R5 set wins flag", {31'd0, tx_valid}, 32'd1);
    chk("R5 set wins data", tx_data, 32'h3333_4444);
    pulse_tx_ready();
    chk("R3 second accept clears", {31'd0, tx_valid}, 32'd0);

    // R6: control side-band
    bus_write(A_TXS, 32'hFFFF_FFFF);
    chk("R6 ctrl bits stored", {1'b0, tx_ctrl}, 32'h7FFF_FFFF);
    chk("R6 bit0 write ignored", {31'd0, tx_valid}, 32'd0);
    bus_read(A_TXS, 32'hFFFF_FFFE, "R6 ctrl readback");
    bus_write(A_TXS, 32'h0000_00A4);
    chk("R6 ctrl rewritten", {1'b0, tx_ctrl}, 32'h0000_0052);

    // R7: receive capture and back-pressure
    rx_valid = 1; rx_data = 32'h1234_5678; rx_ctrl = 31'h15;
    @(negedge clk); #1;
    rx_data = 32'hDEAD_BEEF; rx_ctrl = 31'h2A;
    chk("R7 rx_ready low when full", {31'd0, rx_ready}, 32'd0);
    idle(3);
    chk("R7 still back-pressured", {31'd0, rx_ready}, 32'd0);
    bus_read(A_RXS, 32'h0000_002B, "R7 rx status ctrl+flag");
    rx_valid = 0;
    // R8: read clears
    bus_read(A_RXW, 32'h1234_5678, "R8 rx word first");
    bus_read(A_RXS, 32'h0000_002A, "R8 flag cleared by read");
    chk("R8 rx_ready back high", {31'd0, rx_ready}, 32'd1);

    // R9: capture and read on same edge
    rx_valid = 1; rx_data = 32'hCAFE_0001; rx_ctrl = 31'h01;
    @(negedge clk); #1;
    rx_data = 32'hCAFE_0002; rx_ctrl = 31'h02;
    bus_read(A_RXW, 32'hCAFE_0001, "R9 read returns old word");
    rx_valid = 0;
    bus_read(A_RXS, 32'h0000_0005, "R9 flag kept set");
    bus_read(A_RXW, 32'hCAFE_0002, "R9 new word stored");
    bus_read(A_RXS, 32'h0000_0004, "R8 flag clear after drain");

    // R11: ignored writes and out-of-window reads
    bus_write(A_RXW, 32'hFFFF_FFFF);
    bus_write(A_RXS, 32'hFFFF_FFFF);
    bus_write(10'h210, 32'h5555_5555);
    bus_write(10'h1FC, 32'h6666_6666);
    bus_write(10'h201, 32'h7777_7777);
    chk("R11 unaligned write no tx", {31'd0, tx_valid}, 32'd0);
    chk("R11 tx_data untouched", tx_data, 32'h3333_4444);
    bus_read(A_RXW, 32'hCAFE_0002, "R11 rx word untouched");
    bus_read(A_RXS, 32'h0000_0004, "R11 rx status untouched");
    bus_read(10'h210, 32'h0, "R11 outside window reads zero");
    bus_read(10'h202, 32'h0, "R11 unaligned read zero");

    // R10: back-to-back reads
    bus_sel = 1; bus_wr = 0; bus_addr = A_TXW;
    @(negedge clk); #1;
    bus_addr = A_TXS;
    @(negedge clk);
    chk("R10 back-to-back rvalid", {31'd0, bus_rvalid}, 32'd1);
    #1;
    bus_sel = 0;
    idle(2);

    running = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule